// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block owns the program counter of a 32-bit load/store core whose control transfers take effect one instruction late: the instruction right after a branch or jump, the delay slot, always runs before control reaches the target. Each cycle the core presents the fields of the instruction at the current PC: primary opcode, rt selector, rd selector, function code, 16-bit offset and 26-bit jump index. It also presents the two register operands read for that instruction. When `step` is high the sequencer retires that instruction and moves its two state registers, the current PC and a separate next-PC. A taken transfer only rewrites next-PC. The delay-slot instruction at PC+4 therefore runs first, and the new address reaches PC one step later.

For the linking forms the sequencer drives a register write request: an index and the return address PC+8. The register file applies it on the same clock edge as the step. A direct write port (`pc_load`) sets the PC, for example after an exception or at boot. It takes priority over a step.

Top module: `flow_seq`

## Requirements
- R1: After reset `pc` is 0 and `next_pc` is 4. A `pc_load` cycle sets `pc` to `pc_load_val` and `next_pc` to `pc_load_val`+4, clears any pending delay slot, and takes priority over `step`. No link write is issued in that cycle.
- R2: A step whose instruction does not redirect (for example opcode 0 with function 0x20) moves `pc` to the old `next_pc` and advances `next_pc` by 4.
- R3: A taken conditional branch at address A moves `pc` to A+4 and sets `next_pc` to A+4 plus the sign-extended `offset` times 4. The following step, which runs the delay-slot instruction, moves `pc` to that target.
- R4: Opcode 4 is taken when rs equals rt and opcode 5 when they differ. Opcode 6 is taken when rs, read as a signed value, is at most 0, and opcode 7 when it is above 0.
- R5: Opcode 1 is taken when rs is at least 0 if bit 0 of `rt_sel` is 1, and when rs is below 0 if that bit is 0.
- R6: Opcode 1 with `rt_sel` 0x10 or 0x11 writes PC+8 to register 31, whether or not the branch is taken.
- R7: Opcodes 2 and 3 jump to the address formed by bits 31..28 of PC+4, then `jump_index`, then two zero bits. Opcode 3 also writes PC+8 to register 31.
- R8: Opcode 0 with function 8 jumps to `rs_data`. Function 9 does the same and writes PC+8 to register `rd_sel`.
- R9: A link whose destination index is 0 is dropped: `link_we` stays low.
- R10: An instruction in a delay slot never redirects and never links. Its step moves `pc` to the pending target and sets `next_pc` to that target plus 4.
- R11: With `step` and `pc_load` both low, `pc` and `next_pc` hold and `link_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Retire the instruction at `pc` this cycle |
| pc_load | input | 1 | Direct PC write |
| pc_load_val | input | 32 | Value for the direct PC write |
| opcode | input | 6 | Primary opcode of the current instruction |
| rt_sel | input | 5 | rt field (sub-operation for opcode 1) |
| rd_sel | input | 5 | rd field (link destination for function 9) |
| funct | input | 6 | Function code for opcode 0 |
| offset | input | 16 | Branch offset in words, two's complement |
| jump_index | input | 26 | Word index for direct jumps |
| rs_data | input | 32 | Value of register rs |
| rt_data | input | 32 | Value of register rt |
| pc | output | 32 | Current PC |
| next_pc | output | 32 | Address the PC takes on the next step |
| link_we | output | 1 | Link write request for this step |
| link_idx | output | 5 | Link destination register |
| link_val | output | 32 | Return address PC+8 |

## Verification
The branch conditions are driven on both sides of their boundaries: equal and unequal operands, and rs at -1, 0 and a positive value. This separates signed from unsigned comparison and strict from non-strict comparison. Taken branches use both positive and negative offsets, and each one is followed by its delay-slot step, so a target computed from the wrong base shows up one step later in `pc`. Direct jumps run from a PC with nonzero upper bits to show which PC the region bits are taken from. Branches and jumps placed inside delay slots, a not-taken linking branch, and a register-link jump to index 0 separate a suppressed redirect from a suppressed link.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   // Primary opcode codes that change control flow
   localparam logic [5:0] OPC_REG_FMT   = 6'd0;
   localparam logic [5:0] OPC_SIGN_BR   = 6'd1;
   localparam logic [5:0] OPC_JUMP      = 6'd2;
   localparam logic [5:0] OPC_JUMP_LINK = 6'd3;
   localparam logic [5:0] OPC_BR_EQ     = 6'd4;
   localparam logic [5:0] OPC_BR_NE     = 6'd5;
   localparam logic [5:0] OPC_BR_LEZ    = 6'd6;
   localparam logic [5:0] OPC_BR_GTZ    = 6'd7;
   // Function codes under OPC_REG_FMT
   localparam logic [5:0] FN_JUMP_REG      = 6'd8;
   localparam logic [5:0] FN_JUMP_REG_LINK = 6'd9;
   // rt selector values of the linking sign branches
   localparam logic [4:0] RT_SIGN_LINK_LT = 5'h10;
   localparam logic [4:0] RT_SIGN_LINK_GE = 5'h11;
endpackage

// File: rtl/pcs_cond.sv
module pcs_cond #(
   parameter int W         = 32,
   parameter int CMP_STYLE = 0   // 0: signed compare, 1: sign bit plus zero detect
) (
   input  logic [5:0]   opc,
   input  logic         ge_sel,
   input  logic [W-1:0] rs_val,
   input  logic [W-1:0] rt_val,
   output logic         take
);
   import pcs_pkg::*;

   logic is_neg, is_zero, same;

   generate
      if (CMP_STYLE == 0) begin : g_signed
         assign is_neg  = $signed(rs_val) < 0;
         assign is_zero = $signed(rs_val) == 0;
      end else begin : g_bits
         assign is_neg  = rs_val[W-1];
         assign is_zero = ~|rs_val;
      end
   endgenerate

   assign same = (rs_val == rt_val);

   always_comb begin
      case (opc)
         OPC_BR_EQ:   take = same;
         OPC_BR_NE:   take = !same;
         OPC_BR_LEZ:  take = is_neg | is_zero;
         OPC_BR_GTZ:  take = !is_neg & !is_zero;
         OPC_SIGN_BR: take = ge_sel ? !is_neg : is_neg;
         default:     take = 1'b0;
      endcase
   end
endmodule

// File: rtl/pcs_decode.sv
module pcs_decode #(
   parameter int W        = 32,
   parameter int OFF_W    = 16,
   parameter int JIDX_W   = 26,
   parameter int IDX_W    = 5,
   parameter int LINK_REG = 31
) (
   input  logic [5:0]        opc,
   input  logic [4:0]        rt_sel,
   input  logic [IDX_W-1:0]  rd_sel,
   input  logic [5:0]        funct,
   input  logic [OFF_W-1:0]  offset,
   input  logic [JIDX_W-1:0] jidx,
   input  logic [W-1:0]      rs_val,
   input  logic [W-1:0]      pc,
   input  logic [W-1:0]      npc,
   input  logic              take,
   output logic              redirect,
   output logic [W-1:0]      target,
   output logic              link,
   output logic [IDX_W-1:0]  link_idx
);
   import pcs_pkg::*;

   localparam int REGION_LO = JIDX_W + 2;

   logic [W-1:0] pc4, br_tgt, jd_tgt, off_ext;

   assign pc4     = pc + W'(4);
   assign off_ext = {{(W-OFF_W){offset[OFF_W-1]}}, offset};
   assign br_tgt  = npc + (off_ext << 2);
   assign jd_tgt  = {pc4[W-1:REGION_LO], jidx, 2'b00};

   always_comb begin
      redirect = 1'b0;
      target   = pc4;
      link     = 1'b0;
      link_idx = IDX_W'(LINK_REG);
      case (opc)
         OPC_REG_FMT: begin
            if (funct == FN_JUMP_REG || funct == FN_JUMP_REG_LINK) begin
               redirect = 1'b1;
               target   = rs_val;
               link     = (funct == FN_JUMP_REG_LINK);
               link_idx = rd_sel;
            end
         end
         OPC_SIGN_BR: begin
            redirect = take;
            target   = br_tgt;
            link     = (rt_sel == RT_SIGN_LINK_LT) || (rt_sel == RT_SIGN_LINK_GE);
         end
         OPC_JUMP, OPC_JUMP_LINK: begin
            redirect = 1'b1;
            target   = jd_tgt;
            link     = (opc == OPC_JUMP_LINK);
         end
         OPC_BR_EQ, OPC_BR_NE, OPC_BR_LEZ, OPC_BR_GTZ: begin
            redirect = take;
            target   = br_tgt;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/flow_seq.sv
module flow_seq #(
   parameter int          W         = 32,
   parameter int          OFF_W     = 16,
   parameter int          JIDX_W    = 26,
   parameter int          NREGS     = 32,
   parameter int          LINK_REG  = 31,
   parameter int          CMP_STYLE = 0,
   parameter logic [31:0] RESET_PC  = 32'h0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step,
   input  logic                     pc_load,
   input  logic [W-1:0]             pc_load_val,
   input  logic [5:0]               opcode,
   input  logic [4:0]               rt_sel,
   input  logic [$clog2(NREGS)-1:0] rd_sel,
   input  logic [5:0]               funct,
   input  logic [OFF_W-1:0]         offset,
   input  logic [JIDX_W-1:0]        jump_index,
   input  logic [W-1:0]             rs_data,
   input  logic [W-1:0]             rt_data,
   output logic [W-1:0]             pc,
   output logic [W-1:0]             next_pc,
   output logic                     link_we,
   output logic [$clog2(NREGS)-1:0] link_idx,
   output logic [W-1:0]             link_val
);
   localparam int          IDX_W  = $clog2(NREGS);
   localparam logic [W-1:0] INSN_B = W'(4);

   generate
      if (W <= JIDX_W + 2 || W < OFF_W + 2) begin : g_bad_width
         $error("flow_seq: W too small for offset or jump index");
      end
      if (LINK_REG <= 0 || LINK_REG >= NREGS) begin : g_bad_link
         $error("flow_seq: LINK_REG out of range");
      end
      if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_cmp
         $error("flow_seq: CMP_STYLE must be 0 or 1");
      end
   endgenerate

   logic [W-1:0]     pc_q, npc_q, tgt;
   logic             pend_q, take, redir, lnk;
   logic [IDX_W-1:0] lnk_idx;

   pcs_cond #(.W(W), .CMP_STYLE(CMP_STYLE)) cond_i (
      .opc(opcode), .ge_sel(rt_sel[0]), .rs_val(rs_data), .rt_val(rt_data),
      .take(take)
   );

   pcs_decode #(.W(W), .OFF_W(OFF_W), .JIDX_W(JIDX_W), .IDX_W(IDX_W),
                .LINK_REG(LINK_REG)) dec_i (
      .opc(opcode), .rt_sel(rt_sel), .rd_sel(rd_sel), .funct(funct),
      .offset(offset), .jidx(jump_index), .rs_val(rs_data), .pc(pc_q),
      .npc(npc_q), .take(take), .redirect(redir), .target(tgt),
      .link(lnk), .link_idx(lnk_idx)
   );

   // Delay-slot instructions neither redirect nor link
   logic act, redir_eff;
   assign act       = step && !pc_load && !pend_q;
   assign redir_eff = act && redir;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= W'(RESET_PC);
         npc_q  <= W'(RESET_PC) + INSN_B;
         pend_q <= 1'b0;
      end else if (pc_load) begin
         pc_q   <= pc_load_val;
         npc_q  <= pc_load_val + INSN_B;
         pend_q <= 1'b0;
      end else if (step) begin
         pc_q   <= npc_q;
         npc_q  <= redir_eff ? tgt : npc_q + INSN_B;
         pend_q <= redir_eff;
      end
   end

   assign pc       = pc_q;
   assign next_pc  = npc_q;
   assign link_we  = act && lnk && (lnk_idx != '0);
   assign link_idx = lnk_idx;
   assign link_val = pc_q + W'(8);

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc_q == W'(RESET_PC) && npc_q == W'(RESET_PC) + INSN_B)); // R1
   AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> (pc_q == $past(pc_load_val) && npc_q == $past(pc_load_val) + INSN_B)); // R1
   AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !pc_load) |=> pc_q == $past(npc_q)); // R2
   AST_DELAY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !pc_load && pend_q) |=> npc_q == $past(npc_q) + INSN_B); // R10
   AST_DELAY_NOLINK: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !link_we); // R10
   AST_LINK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> link_idx != '0); // R9
   AST_LINK_RET: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> link_val == pc_q + W'(8)); // R6
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !pc_load) |=> ($stable(pc_q) && $stable(npc_q))); // R11
   AST_IDLE_NOLINK: assert property (@(posedge clk) disable iff (!rst_n)
      !step |-> !link_we); // R11
endmodule

// File: tb/flow_seq_tb_top.sv
module flow_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0, pc_load = 1'b0;
   logic [31:0] pc_load_val = '0;
   logic [5:0]  opcode = '0, funct = '0;
   logic [4:0]  rt_sel = '0, rd_sel = '0;
   logic [15:0] offset = '0;
   logic [25:0] jump_index = '0;
   logic [31:0] rs_data = '0, rt_data = '0;
   logic [31:0] pc, next_pc, link_val;
   logic        link_we;
   logic [4:0]  link_idx;

   int checks = 0, failures = 0;
   bit done = 0;

   // reference state
   logic [31:0] m_pc, m_npc;
   bit          m_pend;

   always #2 clk = ~clk;   // 250 MHz

   flow_seq dut_i (
      .clk(clk), .rst_n(rst_n), .step(step), .pc_load(pc_load),
      .pc_load_val(pc_load_val), .opcode(opcode), .rt_sel(rt_sel),
      .rd_sel(rd_sel), .funct(funct), .offset(offset),
      .jump_index(jump_index), .rs_data(rs_data), .rt_data(rt_data),
      .pc(pc), .next_pc(next_pc), .link_we(link_we),
      .link_idx(link_idx), .link_val(link_val)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One clock: drive, check link outputs, clock, check PC state
   task automatic cyc(input string req, input bit st, input bit ld,
                      input logic [31:0] lv, input logic [5:0] op,
                      input logic [4:0] rt, input logic [4:0] rd,
                      input logic [5:0] fn, input logic [15:0] off,
                      input logic [25:0] ji, input logic [31:0] rsv,
                      input logic [31:0] rtv);
      bit go, lk;
      logic [31:0] tg;
      int lidx;
      @(negedge clk);
      step = st; pc_load = ld; pc_load_val = lv; opcode = op; rt_sel = rt;
      rd_sel = rd; funct = fn; offset = off; jump_index = ji;
      rs_data = rsv; rt_data = rtv;
      go = 0; lk = 0; lidx = 31; tg = 0;
      if (op == 0 && (fn == 8 || fn == 9)) begin
         go = 1; tg = rsv; lk = (fn == 9); lidx = rd;
      end else if (op == 2 || op == 3) begin
         go = 1; lk = (op == 3);
         tg = ((m_pc + 4) & 32'hF000_0000) | (32'(ji) * 4);
      end else if (op >= 1 && op <= 7) begin
         tg = m_npc + 32'(int'($signed(off)) * 4);
         case (op)
            1: begin
               go = rt[0] ? ($signed(rsv) >= 0) : ($signed(rsv) < 0);
               lk = (rt == 5'h10 || rt == 5'h11);
            end
            4: go = (rsv == rtv);
            5: go = (rsv != rtv);
            6: go = ($signed(rsv) <= 0);
            default: go = ($signed(rsv) > 0);
         endcase
      end
      if (!st || ld || m_pend) begin go = 0; lk = 0; end
      if (lidx == 0) lk = 0;
      #1;
      chk(req, "link_we", 32'(link_we), 32'(lk));
      if (lk) begin
         chk(req, "link_idx", 32'(link_idx), 32'(lidx));
         chk(req, "link_val", link_val, m_pc + 8);
      end
      @(posedge clk);
      if (ld) begin
         m_pc = lv; m_npc = lv + 4; m_pend = 0;
      end else if (st) begin
         m_pc = m_npc;
         m_npc = go ? tg : m_npc + 4;
         m_pend = go;
      end
      #1;
      chk(req, "pc", pc, m_pc);
      chk(req, "next_pc", next_pc, m_npc);
   endtask

   task automatic nop(input string req);
      cyc(req, 1, 0, 0, 6'd0, 0, 0, 6'h20, 0, 0, 32'h11, 32'h22);
   endtask
   task automatic br(input string req, input logic [5:0] op, input logic [4:0] rt,
                     input logic [15:0] off, input logic [31:0] rsv,
                     input logic [31:0] rtv);
      cyc(req, 1, 0, 0, op, rt, 0, 0, off, 0, rsv, rtv);
   endtask
   task automatic ld(input string req, input logic [31:0] v);
      cyc(req, 0, 1, v, 0, 0, 0, 6'h20, 0, 0, 0, 0);
   endtask

   initial begin
      #800000;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      if (!done) begin
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      m_pc = 0; m_npc = 4; m_pend = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1", "reset pc", pc, 32'h0);
      chk("R1", "reset next_pc", next_pc, 32'h4);
      // R2 sequential flow
      nop("R2"); nop("R2"); nop("R2");
      // R11 idle
      cyc("R11", 0, 0, 0, 6'd3, 0, 0, 0, 0, 26'h55, 0, 0);
      // R3 R4 beq taken, positive offset, then delay slot
      br("R4", 6'd4, 0, 16'd3, 32'h7, 32'h7);
      nop("R3");
      nop("R3");
      // R1 load, and load beats a step carrying a jump
      ld("R1", 32'h0000_0100);
      cyc("R1", 1, 1, 32'h0000_0200, 6'd3, 0, 0, 0, 0, 26'h10, 0, 0);
      // R4 bne not taken, then taken with negative offset
      br("R4", 6'd5, 0, 16'd8, 32'h5, 32'h5);
      br("R3", 6'd5, 0, 16'hFFFE, 32'h5, 32'h6);
      nop("R3"); nop("R3");
      // R4 blez / bgtz around zero
      br("R4", 6'd6, 0, 16'd4, 32'hFFFF_FFFF, 0); nop("R4");
      br("R4", 6'd6, 0, 16'd4, 32'h0, 0);         nop("R4");
      br("R4", 6'd6, 0, 16'd4, 32'h1, 0);
      br("R4", 6'd7, 0, 16'd4, 32'h1, 0);         nop("R4");
      br("R4", 6'd7, 0, 16'd4, 32'h0, 0);
      br("R4", 6'd7, 0, 16'd4, 32'h8000_0000, 0);
      // R5 sign branches on opcode 1
      br("R5", 6'd1, 5'h01, 16'd2, 32'h0, 0);          nop("R5");
      br("R5", 6'd1, 5'h01, 16'd2, 32'hFFFF_FFFE, 0);
      br("R5", 6'd1, 5'h00, 16'd2, 32'hFFFF_FFFF, 0);  nop("R5");
      br("R5", 6'd1, 5'h00, 16'd2, 32'h3, 0);
      // R6 linking sign branches, taken and not taken
      br("R6", 6'd1, 5'h11, 16'd5, 32'hFFFF_FFFD, 0);
      br("R6", 6'd1, 5'h10, 16'd5, 32'hFFFF_FFFD, 0);  nop("R6");
      br("R6", 6'd1, 5'h11, 16'd1, 32'h4, 0);          nop("R6");
      // R7 direct jumps from a high region
      ld("R7", 32'hA000_0010);
      cyc("R7", 1, 0, 0, 6'd2, 0, 0, 0, 0, 26'h40, 0, 0); nop("R7");
      cyc("R7", 1, 0, 0, 6'd3, 0, 0, 0, 0, 26'h3FF_FFFF, 0, 0); nop("R7");
      // R8 register jumps
      cyc("R8", 1, 0, 0, 6'd0, 0, 5'd7, 6'd8, 0, 0, 32'h0000_0400, 0); nop("R8");
      cyc("R8", 1, 0, 0, 6'd0, 0, 5'd5, 6'd9, 0, 0, 32'h0000_0800, 0); nop("R8");
      // R9 link to register 0 dropped
      cyc("R9", 1, 0, 0, 6'd0, 0, 5'd0, 6'd9, 0, 0, 32'h0000_0900, 0); nop("R9");
      // R10 redirects and links inside a delay slot are ignored
      br("R10", 6'd4, 0, 16'd10, 32'h1, 32'h1);
      br("R10", 6'd4, 0, 16'd40, 32'h1, 32'h1);
      nop("R10");
      cyc("R10", 1, 0, 0, 6'd2, 0, 0, 0, 0, 26'h100, 0, 0);
      cyc("R10", 1, 0, 0, 6'd3, 0, 0, 0, 0, 26'h200, 0, 0);
      nop("R10");
      // R1 load clears a pending delay slot
      br("R1", 6'd4, 0, 16'd10, 32'h1, 32'h1);
      ld("R1", 32'h0000_3000);
      nop("R1");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule